// File: doc/BRIEF.md
# CPU Interrupt and Control Input Conditioner

This block sits between the asynchronous control pins of a small processor core and the core's instruction sequencer. It passes the raw reset, maskable interrupt, non-maskable interrupt and test inputs through two-flop synchronizers. It filters reset for a minimum pulse length and turns a rising edge on the non-maskable input into a pending request. At each instruction boundary it decides whether the core must take an interrupt. While a wait instruction runs, it stalls the core until the test input goes low.

The core supplies three synchronous signals. `eoi_i` marks the last cycle of an instruction. `ie_i` is the interrupt-enable flag. `wait_i` marks the cycle in which a wait instruction starts. The block returns a one-cycle take pulse, a flag that tells a non-maskable take from a maskable one, the fixed type code of the non-maskable case, a qualified core reset and a stall level.

There are three state machines:
- **Reset filter**: RF_IDLE goes to RF_COUNT on the first synchronized reset cycle. RF_COUNT goes to RF_ACTIVE after the minimum number of consecutive high samples, and back to RF_IDLE on any low sample. RF_ACTIVE goes back to RF_IDLE when the synchronized reset falls.
- **Non-maskable latch**: NL_CLEAR goes to NL_PENDING on a rising edge. NL_PENDING goes back to NL_CLEAR on a grant that arrives without a fresh edge, or on the qualified reset.
- **Boundary sequencer**: BS_RUN goes to BS_TAKE_NMI, BS_TAKE_MASK or BS_STALL. BS_STALL goes to either take state, or back to BS_RUN when test falls. Both take states always return to BS_RUN. The qualified reset forces BS_RUN from any state.

Top module: `cpu_ctl_cond`

## Requirements
- R1: A maskable take happens when `eoi_i` is high in BS_RUN, the synchronized interrupt request is high, `ie_i` is high and no non-maskable request is pending. `irq_take_o` is then high for the next cycle, with `irq_is_nmi_o`=0 and `irq_type_o`=0.
- R2: When `ie_i` is low at a boundary, the maskable request is ignored. The request is a level and is not remembered, so if it falls before an enabled boundary it is never taken.
- R3: A low-to-high transition on `nmi_i` leaves a request pending whatever `ie_i` is. The request is taken at the next boundary with `irq_is_nmi_o`=1 and `irq_type_o`=2. A level held high makes no new request.
- R4: Further rising edges that arrive while a non-maskable request is pending merge into it and produce a single take.
- R5: When both requests are present at one boundary, the non-maskable one is taken first. The maskable one is taken at a later boundary.
- R6: `core_rst_o` rises after the sixth rising clock edge at which `rst_i` is high, counted from the first such edge: 2 synchronizer stages plus 4 consecutive samples. It falls three edges after `rst_i` falls.
- R7: A reset pulse seen at fewer than four consecutive edges is discarded. `core_rst_o` stays low and a pending non-maskable request survives.
- R8: `wait_i` with the synchronized test high enters BS_STALL and drives `wait_stall_o` high. The stall ends the third edge after `test_i` falls. `wait_i` with test already low does not stall.
- R9: In BS_STALL every cycle counts as a boundary. An enabled maskable request or a pending non-maskable one is taken without `eoi_i`, and that ends the stall. `core_rst_o` also ends the stall and suppresses takes.
- R10: `irq_take_o` lasts exactly one cycle. An `eoi_i` during the take cycle is not evaluated, and an `eoi_i` with no request has no effect.
- R11: An input change reaches a decision only after two synchronizer edges. A request raised in the same cycle as `eoi_i` is first taken at the third consecutive boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_i | input | 1 | Raw asynchronous reset request, active high |
| intr_i | input | 1 | Raw maskable interrupt request, level, active high |
| nmi_i | input | 1 | Raw non-maskable interrupt, rising-edge sensitive |
| test_i | input | 1 | Raw test input; high holds a running wait instruction |
| ie_i | input | 1 | Interrupt-enable flag from the core (synchronous) |
| eoi_i | input | 1 | Last cycle of the current instruction (synchronous) |
| wait_i | input | 1 | Wait instruction starts this cycle (synchronous) |
| core_rst_o | output | 1 | Qualified, length-filtered core reset |
| irq_take_o | output | 1 | One-cycle request to enter interrupt acknowledge |
| irq_is_nmi_o | output | 1 | Current take is the non-maskable one |
| irq_type_o | output | TYPE_W | Type code: 2 for a non-maskable take, else 0 |
| wait_stall_o | output | 1 | Core must idle in the wait instruction |

## Verification
The assertions check the following on every cycle:
- take pulses last one cycle and always start at a boundary;
- maskable takes follow an enabled flag;
- the non-maskable type code is correct;
- the reset output rises only after enough consecutive synchronized reset samples;
- the qualified reset quiets takes and stall;
- a stall ends only through test low, a take or reset.

Only the bench's scenarios can show the exact synchronizer latency, edge merging, NMI-over-maskable priority, the survival of a pending request across a discarded reset pulse, and that a level request which falls before an enabled boundary is lost.

// File: rtl/cic_pkg.sv
`timescale 1ns/1ps
package cic_pkg;

    typedef enum logic [1:0] {
        RF_IDLE,
        RF_COUNT,
        RF_ACTIVE
    } rst_state_e;

    typedef enum logic {
        NL_CLEAR,
        NL_PENDING
    } nmi_state_e;

    typedef enum logic [1:0] {
        BS_RUN,
        BS_STALL,
        BS_TAKE_MASK,
        BS_TAKE_NMI
    } bnd_state_e;

endpackage

// File: rtl/cic_sync.sv
`timescale 1ns/1ps
module cic_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    chain[0] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain[STAGES-1];

endmodule

// File: rtl/cic_rst_filter.sv
`timescale 1ns/1ps
module cic_rst_filter
    import cic_pkg::*;
#(
    parameter int MIN_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_s_i,
    output logic core_rst_o
);

    localparam int CNT_W = $clog2(MIN_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(MIN_CYCLES - 1);

    rst_state_e       state_q, state_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;

    // State register
    always_ff @(posedge clk) begin
        state_q <= state_n;
        cnt_q   <= cnt_n;
    end

    // Next state: count consecutive synchronized reset samples
    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        unique case (state_q)
            RF_IDLE: begin
                cnt_n = '0;
                if (rst_s_i) begin
                    if (MIN_CYCLES <= 1) begin
                        state_n = RF_ACTIVE;
                    end else begin
                        state_n = RF_COUNT;
                        cnt_n   = CNT_W'(1);
                    end
                end
            end
            RF_COUNT: begin
                if (!rst_s_i) begin
                    state_n = RF_IDLE;
                    cnt_n   = '0;
                end else if (cnt_q == LAST) begin
                    state_n = RF_ACTIVE;
                    cnt_n   = '0;
                end else begin
                    cnt_n = cnt_q + CNT_W'(1);
                end
            end
            RF_ACTIVE: begin
                cnt_n = '0;
                if (!rst_s_i) begin
                    state_n = RF_IDLE;
                end
            end
            default: begin
                state_n = RF_IDLE;
                cnt_n   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        core_rst_o = (state_q == RF_ACTIVE);
    end

endmodule

// File: rtl/cic_nmi_latch.sv
`timescale 1ns/1ps
module cic_nmi_latch
    import cic_pkg::*;
(
    input  logic clk,
    input  logic clr_i,
    input  logic nmi_s_i,
    input  logic grant_i,
    output logic pend_o
);

    nmi_state_e state_q, state_n;
    logic       prev_q;
    logic       rise;

    assign rise = nmi_s_i & ~prev_q;

    // State register
    always_ff @(posedge clk) begin
        state_q <= state_n;
        prev_q  <= nmi_s_i;
    end

    // Next state: hold one request, merge repeats
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            NL_CLEAR: begin
                if (rise) begin
                    state_n = NL_PENDING;
                end
            end
            NL_PENDING: begin
                if (grant_i && !rise) begin
                    state_n = NL_CLEAR;
                end
            end
            default: state_n = NL_CLEAR;
        endcase
        if (clr_i) begin
            state_n = NL_CLEAR;
        end
    end

    // Outputs
    always_comb begin
        pend_o = (state_q == NL_PENDING);
    end

endmodule

// File: rtl/cic_boundary.sv
`timescale 1ns/1ps
module cic_boundary
    import cic_pkg::*;
#(
    parameter int              TYPE_W   = 8,
    parameter logic [TYPE_W-1:0] NMI_TYPE = TYPE_W'(2)
) (
    input  logic              clk,
    input  logic              clr_i,
    input  logic              eoi_i,
    input  logic              wait_i,
    input  logic              ie_i,
    input  logic              intr_s_i,
    input  logic              test_s_i,
    input  logic              nmi_pend_i,
    output logic              grant_nmi_o,
    output logic              take_o,
    output logic              is_nmi_o,
    output logic [TYPE_W-1:0] type_o,
    output logic              stall_o
);

    bnd_state_e state_q, state_n;
    logic       boundary;
    logic       nmi_go;
    logic       mask_go;

    // A stalled core is interruptible on every cycle
    assign boundary = ((state_q == BS_RUN) && eoi_i) || (state_q == BS_STALL);
    assign nmi_go   = boundary && nmi_pend_i;
    assign mask_go  = boundary && intr_s_i && ie_i && !nmi_pend_i;

    // State register
    always_ff @(posedge clk) begin
        state_q <= state_n;
    end

    // Next state
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            BS_RUN: begin
                if (nmi_go) begin
                    state_n = BS_TAKE_NMI;
                end else if (mask_go) begin
                    state_n = BS_TAKE_MASK;
                end else if (wait_i && test_s_i) begin
                    state_n = BS_STALL;
                end
            end
            BS_STALL: begin
                if (nmi_go) begin
                    state_n = BS_TAKE_NMI;
                end else if (mask_go) begin
                    state_n = BS_TAKE_MASK;
                end else if (!test_s_i) begin
                    state_n = BS_RUN;
                end
            end
            BS_TAKE_MASK: state_n = BS_RUN;
            BS_TAKE_NMI:  state_n = BS_RUN;
            default:      state_n = BS_RUN;
        endcase
        if (clr_i) begin
            state_n = BS_RUN;
        end
    end

    // Outputs
    always_comb begin
        grant_nmi_o = nmi_go && !clr_i;
        take_o      = (state_q == BS_TAKE_MASK) || (state_q == BS_TAKE_NMI);
        is_nmi_o    = (state_q == BS_TAKE_NMI);
        type_o      = (state_q == BS_TAKE_NMI) ? NMI_TYPE : '0;
        stall_o     = (state_q == BS_STALL);
    end

endmodule

// File: rtl/cpu_ctl_cond.sv
`timescale 1ns/1ps
module cpu_ctl_cond #(
    parameter int                SYNC_STAGES    = 2,
    parameter int                RST_MIN_CYCLES = 4,
    parameter int                TYPE_W         = 8,
    parameter logic [TYPE_W-1:0] NMI_TYPE       = TYPE_W'(2)
) (
    input  logic              clk,
    input  logic              rst_i,
    input  logic              intr_i,
    input  logic              nmi_i,
    input  logic              test_i,
    input  logic              ie_i,
    input  logic              eoi_i,
    input  logic              wait_i,
    output logic              core_rst_o,
    output logic              irq_take_o,
    output logic              irq_is_nmi_o,
    output logic [TYPE_W-1:0] irq_type_o,
    output logic              wait_stall_o
);

    localparam int N_IN = 4;
    localparam int B_RST  = 3;
    localparam int B_INTR = 2;
    localparam int B_NMI  = 1;
    localparam int B_TEST = 0;

    logic [N_IN-1:0] raw_in;
    logic [N_IN-1:0] sync_in;
    logic            rst_s;
    logic            intr_s;
    logic            nmi_s;
    logic            test_s;
    logic            nmi_pend;
    logic            nmi_grant;

    assign raw_in = {rst_i, intr_i, nmi_i, test_i};
    assign rst_s  = sync_in[B_RST];
    assign intr_s = sync_in[B_INTR];
    assign nmi_s  = sync_in[B_NMI];
    assign test_s = sync_in[B_TEST];

    cic_sync #(
        .WIDTH  (N_IN),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk     (clk),
        .async_i (raw_in),
        .sync_o  (sync_in)
    );

    cic_rst_filter #(
        .MIN_CYCLES (RST_MIN_CYCLES)
    ) rst_flt_i (
        .clk        (clk),
        .rst_s_i    (rst_s),
        .core_rst_o (core_rst_o)
    );

    cic_nmi_latch nmi_i_latch (
        .clk     (clk),
        .clr_i   (core_rst_o),
        .nmi_s_i (nmi_s),
        .grant_i (nmi_grant),
        .pend_o  (nmi_pend)
    );

    cic_boundary #(
        .TYPE_W   (TYPE_W),
        .NMI_TYPE (NMI_TYPE)
    ) bnd_i (
        .clk         (clk),
        .clr_i       (core_rst_o),
        .eoi_i       (eoi_i),
        .wait_i      (wait_i),
        .ie_i        (ie_i),
        .intr_s_i    (intr_s),
        .test_s_i    (test_s),
        .nmi_pend_i  (nmi_pend),
        .grant_nmi_o (nmi_grant),
        .take_o      (irq_take_o),
        .is_nmi_o    (irq_is_nmi_o),
        .type_o      (irq_type_o),
        .stall_o     (wait_stall_o)
    );

endmodule

// File: rtl/cpu_ctl_cond_chk.sv
`timescale 1ns/1ps
module cpu_ctl_cond_chk #(
    parameter int                RST_MIN_CYCLES = 4,
    parameter int                TYPE_W         = 8,
    parameter logic [TYPE_W-1:0] NMI_TYPE       = TYPE_W'(2)
) (
    input logic              clk,
    input logic              eoi_i,
    input logic              ie_i,
    input logic              rst_s,
    input logic              test_s,
    input logic              core_rst_o,
    input logic              irq_take_o,
    input logic              irq_is_nmi_o,
    input logic [TYPE_W-1:0] irq_type_o,
    input logic              wait_stall_o
);

    localparam int RUN_W = $clog2(RST_MIN_CYCLES + 1) + 1;

    logic             armed = 1'b0;
    logic [RUN_W-1:0] run_cnt = '0;

    always_ff @(posedge clk) begin
        armed <= armed | core_rst_o;
        if (!rst_s) begin
            run_cnt <= '0;
        end else if (run_cnt < RUN_W'(RST_MIN_CYCLES)) begin
            run_cnt <= run_cnt + RUN_W'(1);
        end
    end

    p_take_single_r10: assert property (@(posedge clk) disable iff (!armed)
        irq_take_o |=> !irq_take_o);

    p_nmi_code_r3: assert property (@(posedge clk) disable iff (!armed)
        (irq_take_o && irq_is_nmi_o) |-> (irq_type_o == NMI_TYPE));

    p_take_at_boundary_r1: assert property (@(posedge clk) disable iff (!armed)
        $rose(irq_take_o) |-> ($past(eoi_i) || $past(wait_stall_o)));

    p_mask_needs_ie_r2: assert property (@(posedge clk) disable iff (!armed)
        (irq_take_o && !irq_is_nmi_o) |-> $past(ie_i));

    p_rst_min_len_r6: assert property (@(posedge clk) disable iff (!armed)
        $rose(core_rst_o) |-> (run_cnt >= RUN_W'(RST_MIN_CYCLES)));

    p_rst_quiets_r9: assert property (@(posedge clk) disable iff (!armed)
        core_rst_o |=> (!irq_take_o && !wait_stall_o));

    p_stall_exit_r8: assert property (@(posedge clk) disable iff (!armed)
        $fell(wait_stall_o) |-> (irq_take_o || $past(core_rst_o) || !$past(test_s)));

endmodule

bind cpu_ctl_cond cpu_ctl_cond_chk #(
    .RST_MIN_CYCLES (RST_MIN_CYCLES),
    .TYPE_W         (TYPE_W),
    .NMI_TYPE       (NMI_TYPE)
) chk_i (
    .clk          (clk),
    .eoi_i        (eoi_i),
    .ie_i         (ie_i),
    .rst_s        (rst_s),
    .test_s       (test_s),
    .core_rst_o   (core_rst_o),
    .irq_take_o   (irq_take_o),
    .irq_is_nmi_o (irq_is_nmi_o),
    .irq_type_o   (irq_type_o),
    .wait_stall_o (wait_stall_o)
);

// File: tb/cpu_ctl_cond_tb_top.sv
`timescale 1ns/1ps
module cpu_ctl_cond_tb_top;

    localparam int MIN_RST  = 4;
    localparam int WD_LIMIT = 150000;

    logic       clk = 1'b0;
    logic       rst_i = 1'b1;
    logic       intr_i = 1'b0;
    logic       nmi_i = 1'b0;
    logic       test_i = 1'b0;
    logic       ie_i = 1'b0;
    logic       eoi_i = 1'b0;
    logic       wait_i = 1'b0;
    logic       core_rst_o;
    logic       irq_take_o;
    logic       irq_is_nmi_o;
    logic [7:0] irq_type_o;
    logic       wait_stall_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cpu_ctl_cond dut_i (
        .clk          (clk),
        .rst_i        (rst_i),
        .intr_i       (intr_i),
        .nmi_i        (nmi_i),
        .test_i       (test_i),
        .ie_i         (ie_i),
        .eoi_i        (eoi_i),
        .wait_i       (wait_i),
        .core_rst_o   (core_rst_o),
        .irq_take_o   (irq_take_o),
        .irq_is_nmi_o (irq_is_nmi_o),
        .irq_type_o   (irq_type_o),
        .wait_stall_o (wait_stall_o)
    );

    // Reference model built from the requirements: states 0 run, 1 stall, 2 mask take, 3 nmi take
    logic [3:0] m_s1 = '0;
    logic [3:0] m_s2 = '0;
    int         m_cnt = 0;
    bit         m_ract = 1'b0;
    bit         m_prev = 1'b0;
    bit         m_pend = 1'b0;
    int         m_st = 0;
    bit         m_armed = 1'b0;

    function automatic int next_state(int st, bit bnd_eoi, bit pend, bit rq, bit ie,
                                      bit ts, bit wt, bit rst);
        bit bnd;
        int nx;
        bnd = (st == 0 && bnd_eoi) || st == 1;
        nx  = st;
        if (st == 0) begin
            if (bnd && pend) nx = 3;
            else if (bnd && rq && ie) nx = 2;
            else if (wt && ts) nx = 1;
        end else if (st == 1) begin
            if (pend) nx = 3;
            else if (rq && ie) nx = 2;
            else if (!ts) nx = 0;
        end else begin
            nx = 0;
        end
        if (rst) nx = 0;
        return nx;
    endfunction

    always @(posedge clk) begin : model
        bit rs, rq, ns, ts, grant, rise;
        rs = m_s2[3];
        rq = m_s2[2];
        ns = m_s2[1];
        ts = m_s2[0];
        grant = (((m_st == 0) && eoi_i) || m_st == 1) && m_pend && !m_ract;
        rise  = ns && !m_prev;
        m_st   <= next_state(m_st, eoi_i, m_pend, rq, ie_i, ts, wait_i, m_ract);
        m_pend <= m_ract ? 1'b0 : (rise || (m_pend && !grant));
        m_prev <= ns;
        if (!rs) begin
            m_ract <= 1'b0;
            m_cnt  <= 0;
        end else if (!m_ract) begin
            if (m_cnt == MIN_RST - 1) begin
                m_ract <= 1'b1;
                m_cnt  <= 0;
            end else begin
                m_cnt <= m_cnt + 1;
            end
        end
        if (m_ract) m_armed <= 1'b1;
        m_s2 <= m_s1;
        m_s1 <= {rst_i, intr_i, nmi_i, test_i};
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_model();
        string tg;
        if (!m_armed) return;
        tg = (m_st == 3) ? "R3" : (m_st == 2) ? "R1" : (m_st == 1) ? "R8" : "R10";
        check("R6 core_rst", int'(core_rst_o), int'(m_ract));
        check(tg, int'(irq_take_o), int'(m_st >= 2));
        check(tg, int'(irq_is_nmi_o), int'(m_st == 3));
        check("R3 type", int'(irq_type_o), (m_st == 3) ? 2 : 0);
        check("R8 stall", int'(wait_stall_o), int'(m_st == 1));
    endtask

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            compare_model();
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin : watchdog
        repeat (WD_LIMIT) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin : stim
        int hold;
        void'($urandom(32'd7331));
        // R6: power-up reset held, qualified reset after sixth edge
        repeat (6) @(posedge clk);
        @(negedge clk);
        check("R6 first assert", int'(core_rst_o), 1);
        step(3);
        rst_i = 1'b0;
        step(2);
        check("R6 release lag", int'(core_rst_o), 1);
        step(1);
        check("R6 release", int'(core_rst_o), 0);
        step(4);
        // R6: exact threshold on a second reset
        rst_i = 1'b1;
        step(5);
        check("R6 not yet", int'(core_rst_o), 0);
        step(1);
        check("R6 asserted", int'(core_rst_o), 1);
        rst_i = 1'b0;
        step(6);

        // R7: short reset discarded, pending NMI survives
        nmi_i = 1'b1;
        step(4);
        rst_i = 1'b1;
        step(3);
        rst_i = 1'b0;
        for (int i = 0; i < 8; i++) begin
            step(1);
            check("R7 short pulse", int'(core_rst_o), 0);
        end
        eoi_i = 1'b1;
        step(1);
        check("R7 pending kept take", int'(irq_take_o), 1);
        check("R7 pending kept nmi", int'(irq_is_nmi_o), 1);
        eoi_i = 1'b0;
        step(2);

        // R2: disabled flag, and a level that falls is lost
        ie_i = 1'b0; intr_i = 1'b1;
        step(3);
        eoi_i = 1'b1;
        step(1);
        check("R2 masked", int'(irq_take_o), 0);
        eoi_i = 1'b0; intr_i = 1'b0; ie_i = 1'b1;
        step(3);
        eoi_i = 1'b1;
        step(1);
        check("R2 level lost", int'(irq_take_o), 0);
        eoi_i = 1'b0;
        step(1);

        // R1: enabled maskable take
        intr_i = 1'b1;
        step(3);
        eoi_i = 1'b1;
        step(1);
        check("R1 take", int'(irq_take_o), 1);
        check("R1 not nmi", int'(irq_is_nmi_o), 0);
        check("R1 type zero", int'(irq_type_o), 0);
        eoi_i = 1'b0;
        step(1);
        check("R1 single", int'(irq_take_o), 0);

        // R10: boundary during take cycle ignored; idle boundary no effect
        eoi_i = 1'b1;
        step(1);
        check("R10 take", int'(irq_take_o), 1);
        step(1);
        check("R10 ignored in take", int'(irq_take_o), 0);
        step(1);
        check("R10 next boundary", int'(irq_take_o), 1);
        eoi_i = 1'b0; intr_i = 1'b0;
        step(4);
        eoi_i = 1'b1;
        step(1);
        check("R10 empty boundary", int'(irq_take_o), 0);
        eoi_i = 1'b0;
        step(1);

        // R11: synchronizer latency
        intr_i = 1'b1; eoi_i = 1'b1;
        step(1);
        check("R11 edge1", int'(irq_take_o), 0);
        step(1);
        check("R11 edge2", int'(irq_take_o), 0);
        step(1);
        check("R11 edge3", int'(irq_take_o), 1);
        eoi_i = 1'b0; intr_i = 1'b0;
        step(4);

        // R3: NMI with flag cleared, held level gives no second take
        ie_i = 1'b0; nmi_i = 1'b0;
        step(3);
        nmi_i = 1'b1;
        step(4);
        eoi_i = 1'b1;
        step(1);
        check("R3 take", int'(irq_take_o), 1);
        check("R3 nmi", int'(irq_is_nmi_o), 1);
        check("R3 type two", int'(irq_type_o), 2);
        eoi_i = 1'b0;
        step(1);
        eoi_i = 1'b1;
        step(1);
        check("R3 level no retake", int'(irq_take_o), 0);
        eoi_i = 1'b0;
        step(1);

        // R4: two edges merge
        nmi_i = 1'b0; step(3);
        nmi_i = 1'b1; step(3);
        nmi_i = 1'b0; step(3);
        nmi_i = 1'b1; step(3);
        eoi_i = 1'b1;
        step(1);
        check("R4 one take", int'(irq_take_o), 1);
        eoi_i = 1'b0;
        step(1);
        eoi_i = 1'b1;
        step(1);
        check("R4 merged", int'(irq_take_o), 0);
        eoi_i = 1'b0;
        step(1);

        // R5: priority
        nmi_i = 1'b0; step(3);
        ie_i = 1'b1; intr_i = 1'b1; nmi_i = 1'b1;
        step(4);
        eoi_i = 1'b1;
        step(1);
        check("R5 nmi first", int'(irq_is_nmi_o), 1);
        eoi_i = 1'b0;
        step(1);
        eoi_i = 1'b1;
        step(1);
        check("R5 mask later take", int'(irq_take_o), 1);
        check("R5 mask later kind", int'(irq_is_nmi_o), 0);
        eoi_i = 1'b0; intr_i = 1'b0;
        step(4);

        // R8: wait stall and release
        test_i = 1'b1;
        step(3);
        wait_i = 1'b1;
        step(1);
        wait_i = 1'b0;
        check("R8 stall", int'(wait_stall_o), 1);
        step(5);
        check("R8 hold", int'(wait_stall_o), 1);
        test_i = 1'b0;
        step(2);
        check("R8 sync lag", int'(wait_stall_o), 1);
        step(1);
        check("R8 released", int'(wait_stall_o), 0);
        wait_i = 1'b1;
        step(1);
        wait_i = 1'b0;
        check("R8 no stall test low", int'(wait_stall_o), 0);
        step(1);

        // R9: interrupt and reset end the stall
        test_i = 1'b1;
        step(3);
        wait_i = 1'b1;
        step(1);
        wait_i = 1'b0;
        intr_i = 1'b1;
        step(3);
        check("R9 take in stall", int'(irq_take_o), 1);
        check("R9 stall ended", int'(wait_stall_o), 0);
        intr_i = 1'b0;
        step(1);
        check("R9 back to run", int'(wait_stall_o), 0);
        step(3);
        wait_i = 1'b1;
        step(1);
        wait_i = 1'b0;
        rst_i = 1'b1;
        step(7);
        check("R9 reset clears stall", int'(wait_stall_o), 0);
        rst_i = 1'b0;
        step(4);
        check("R9 stays cleared", int'(wait_stall_o), 0);
        test_i = 1'b0;
        step(3);

        // Random phase against the model
        hold = 0;
        for (int c = 0; c < 5000; c++) begin
            if (hold > 0) begin
                hold--;
                rst_i = 1'b1;
            end else begin
                rst_i = 1'b0;
                if ($urandom_range(0, 299) == 0) hold = 1 + $urandom_range(0, 7);
            end
            if ($urandom_range(0, 5) == 0)  intr_i = ~intr_i;
            if ($urandom_range(0, 7) == 0)  nmi_i  = ~nmi_i;
            if ($urandom_range(0, 9) == 0)  test_i = ~test_i;
            if ($urandom_range(0, 3) == 0)  ie_i   = ~ie_i;
            eoi_i  = ($urandom_range(0, 2) == 0);
            wait_i = ($urandom_range(0, 11) == 0);
            step(1);
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule